// File: doc/BRIEF.md
# DDR Write-Turnaround Command Spacing Guard

This block sits between a DDR SDRAM command scheduler and the memory command bus. It remembers the most recent WRITE and tells the scheduler, in the same cycle, whether a READ or a PRECHARGE may be issued yet. A READ aimed at the bank and row that were just written waits a short internal write-to-read delay. A READ aimed at any other bank or row waits a longer, programmable turnaround spacing. A PRECHARGE waits a write-recovery delay.

The three delays are taken from a 32-bit timing register on a simple word-wide register port. Each WRITE captures the register contents in force during its own cycle and reloads every countdown. The scheduler presents its next candidate command, with bank and row, and issues it only while the matching permit is high.

The different-row spacing is sized as write-data latency (1 clock) plus half the burst (2 clocks for a burst of 4) plus a bus turnaround of 1 or 2 clocks, minus a CAS latency of 2 or 2.5. With one clock of turnaround and CAS latency 2 this comes to 2 clocks. Reserved encodings fall back to the slowest legal value and raise a sticky flag.

Top module: `wr_turn_guard`

## Requirements
- R1: The timing register reads as 0x18004425 after reset at word offset 0x60. Any other offset reads 0, and writes to any other offset leave the register unchanged.
- R2: A write to offset 0x60 replaces all 32 bits, and the new value reads back from the following cycle.
- R3: Bit 31 sets the gap between a WRITE and a READ to the same bank and row. Value 0 gives 1 clock. Value 1 is reserved and gives 2 clocks.
- R4: Bit 30 sets the gap between a WRITE and a PRECHARGE. Value 0 gives 2 clocks and value 1 gives 3 clocks.
- R5: Bits 29:28 set the gap between a WRITE and a READ to a different bank or row. The codes 00, 01 and 10 give 4, 3 and 2 clocks. Code 11 is reserved and gives 4 clocks.
- R6: The same-row gap applies only when both bank and row equal those of the last WRITE. A difference in either one selects the different-row gap.
- R7: Each WRITE (cmd_valid_i high with cmd_type_i = 2'b10) reloads all gaps from the register value of its own cycle, even while an earlier countdown is still running. A command with cmd_valid_i low, or one of type READ (2'b01), PRECHARGE (2'b11) or NOP (2'b00), leaves the timers untouched.
- R8: cfg_err_o goes high in the cycle after a register write that carries a reserved code in bit 31 or bits 29:28. It stays high until reset.
- R9: A gap of N clocks means the permit is low for the first N-1 cycles after the WRITE cycle and high from cycle N on. Permits are combinational in the presented bank and row, and are high when no WRITE has occurred since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cmd_valid_i | input | 1 | Candidate command valid |
| cmd_type_i | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 PRECHARGE |
| cmd_bank_i | input | 2 | Target bank of candidate command |
| cmd_row_i | input | 13 | Target row of candidate command |
| rd_ok_o | output | 1 | A READ to the presented bank/row may issue |
| pre_ok_o | output | 1 | A PRECHARGE may issue |
| cfg_err_o | output | 1 | Sticky reserved-encoding flag |

## Verification
The embedded properties check several rules on every cycle:
- a WRITE always blocks PRECHARGE and different-row READs in the next cycle;
- every countdown reloads on a WRITE and otherwise only ever steps down by one;
- a write to a foreign offset never disturbs the register;
- the error flag never falls.

The exact gap length for each encoding, the choice between the same-row and different-row gap, a WRITE landing mid-countdown, and the flag being cleared by reset can be shown only by the bench. Its reference model sweeps all sixteen combinations of the top nibble, and its scenarios cover these cases.

// File: rtl/wtg_pkg.sv
package wtg_pkg;
  localparam int CNT_W = 3;
  localparam int N_TMR = 3;
  localparam int T_WTR = 0;
  localparam int T_REC = 1;
  localparam int T_DIF = 2;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;

  function automatic logic cfg_reserved(input logic [31:0] v);
    return v[31] | (v[29:28] == 2'b11);
  endfunction
endpackage

// File: rtl/wtg_cfg_reg.sv
module wtg_cfg_reg
  import wtg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS = 8'h60,
  parameter logic [31:0] RST = 32'h1800_4425
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [CNT_W-1:0]  wtr_ld_o,
  output logic [CNT_W-1:0]  rec_ld_o,
  output logic [CNT_W-1:0]  dif_ld_o,
  output logic              err_o
);
  logic [31:0] cfg_q;
  logic        err_q;
  logic        hit;

  assign hit = (addr_i == OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST;
      err_q <= 1'b0;
    end else if (we_i && hit) begin
      cfg_q <= wdata_i;
      err_q <= err_q | cfg_reserved(wdata_i);
    end
  end

  assign rdata_o = hit ? cfg_q : '0;
  assign err_o   = err_q;

  // load value = gap - 1; reserved codes take the slowest value
  assign wtr_ld_o = cfg_q[31] ? CNT_W'(1) : CNT_W'(0);
  assign rec_ld_o = cfg_q[30] ? CNT_W'(2) : CNT_W'(1);
  always_comb begin
    unique case (cfg_q[29:28])
      2'b00:   dif_ld_o = CNT_W'(3);
      2'b01:   dif_ld_o = CNT_W'(2);
      2'b10:   dif_ld_o = CNT_W'(1);
      default: dif_ld_o = CNT_W'(3);
    endcase
  end

  assert_foreign_wr_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> (cfg_q == $past(cfg_q)));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/wtg_gap_timer.sv
module wtg_gap_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
  assert_countdown_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wr_turn_guard.sv
module wr_turn_guard
  import wtg_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h60,
  parameter logic [31:0] REG_RST = 32'h1800_4425
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_type_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [ROW_W-1:0]  cmd_row_i,
  output logic              rd_ok_o,
  output logic              pre_ok_o,
  output logic              cfg_err_o
);
  logic [CNT_W-1:0] ld [N_TMR];
  logic [N_TMR-1:0] zero;
  logic             wr_fire;
  logic             same_hit;
  logic [BANK_W-1:0] last_bank_q;
  logic [ROW_W-1:0]  last_row_q;

  assign wr_fire = cmd_valid_i && (cmd_e'(cmd_type_i) == CMD_WR);

  wtg_cfg_reg #(.ADDR_W(ADDR_W), .OFS(REG_OFS), .RST(REG_RST)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .wtr_ld_o (ld[T_WTR]),
    .rec_ld_o (ld[T_REC]),
    .dif_ld_o (ld[T_DIF]),
    .err_o    (cfg_err_o)
  );

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    wtg_gap_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (wr_fire),
      .val_i  (ld[gi]),
      .zero_o (zero[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_bank_q <= '0;
      last_row_q  <= '0;
    end else if (wr_fire) begin
      last_bank_q <= cmd_bank_i;
      last_row_q  <= cmd_row_i;
    end
  end

  // before any write all timers sit at zero, so the match result is moot
  assign same_hit = (cmd_bank_i == last_bank_q) && (cmd_row_i == last_row_q);
  assign rd_ok_o  = same_hit ? zero[T_WTR] : zero[T_DIF];
  assign pre_ok_o = zero[T_REC];

  assert_pre_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !pre_ok_o);
  assert_diff_row_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (!rd_ok_o ||
                 (cmd_bank_i == $past(cmd_bank_i) && cmd_row_i == $past(cmd_row_i))));
endmodule

// File: tb/sim_wr_turn_guard.sv
module sim_wr_turn_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  OFS = 8'h60;
  localparam logic [31:0] RSTV = 32'h1800_4425;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = OFS;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_type_i = 2'b00;
  logic [1:0]  cmd_bank_i = '0;
  logic [12:0] cmd_row_i = '0;
  logic        rd_ok_o, pre_ok_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_reg;
  bit          m_err, m_seen;
  int          n, m_at, m_wtr, m_rec, m_dif;
  logic [1:0]  m_bank;
  logic [12:0] m_row;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wr_turn_guard u0 (.*);

  function automatic int gap_wtr(input logic [31:0] v); return v[31] ? 2 : 1; endfunction
  function automatic int gap_rec(input logic [31:0] v); return v[30] ? 3 : 2; endfunction
  function automatic int gap_dif(input logic [31:0] v);
    case (v[29:28]) 2'b00: return 4; 2'b01: return 3; 2'b10: return 2; default: return 4; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, n);
    end
  endtask

  task automatic model_reset();
    m_reg = RSTV; m_err = 0; m_seen = 0; m_at = 0; m_bank = '0; m_row = '0;
    m_wtr = 1; m_rec = 2; m_dif = 4;
  endtask

  task automatic cyc(input bit v, input logic [1:0] t, input logic [1:0] b, input logic [12:0] r);
    bit same, e_rd, e_pre;
    logic [31:0] e_rdata;
    cmd_valid_i = v; cmd_type_i = t; cmd_bank_i = b; cmd_row_i = r;
    #1;
    same  = (b == m_bank) && (r == m_row);
    e_rd  = !m_seen || ((n - m_at) >= (same ? m_wtr : m_dif));
    e_pre = !m_seen || ((n - m_at) >= m_rec);
    e_rdata = (reg_addr_i == OFS) ? m_reg : 32'h0;
    if (same) chk(rd_ok_o == e_rd, "R3/R6 same-row rd_ok", rd_ok_o, e_rd);
    else      chk(rd_ok_o == e_rd, "R5/R6 diff-row rd_ok", rd_ok_o, e_rd);
    chk(pre_ok_o == e_pre, "R4 pre_ok", pre_ok_o, e_pre);
    chk(cfg_err_o == m_err, "R8 cfg_err", cfg_err_o, m_err);
    chk(reg_rdata_o == e_rdata, "R1/R2 rdata", reg_rdata_o, e_rdata);
    @(posedge clk_i);
    if (v && t == 2'b10) begin
      m_seen = 1; m_at = n; m_bank = b; m_row = r;
      m_wtr = gap_wtr(m_reg); m_rec = gap_rec(m_reg); m_dif = gap_dif(m_reg);
    end
    if (reg_we_i && reg_addr_i == OFS) begin
      m_reg = reg_wdata_i;
      m_err = m_err | reg_wdata_i[31] | (reg_wdata_i[29:28] == 2'b11);
    end
    n++;
    @(negedge clk_i);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc(1'b0, 2'b10, 2'd0, 13'd0);   // valid low: must not load (R7)
    reg_we_i = 1'b0; reg_addr_i = OFS;
  endtask

  task automatic idle(input int k, input logic [1:0] b, input logic [12:0] r, input logic [1:0] t);
    for (int i = 0; i < k; i++) cyc(1'b1, t, b, r);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; #1; model_reset();
    @(posedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    n = 0; model_reset();
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: idle permits; R1: reset value and foreign offsets
    idle(2, 2'd3, 13'd77, 2'b01);
    reg_addr_i = 8'h64; cyc(1'b0, 2'b00, 2'd0, 13'd0);
    reg_wr(8'h64, 32'hFFFF_FFFF);
    reg_addr_i = OFS; cyc(1'b0, 2'b00, 2'd0, 13'd0);
    // R7: non-write commands do not start timers
    cyc(1'b1, 2'b01, 2'd1, 13'd5); cyc(1'b1, 2'b11, 2'd1, 13'd5);
    cyc(1'b1, 2'b00, 2'd1, 13'd5);
    // sweep every top-nibble encoding (R2..R6)
    for (int e = 0; e < 16; e++) begin
      reg_wr(OFS, {e[3:0], 28'h000_4425});
      cyc(1'b1, 2'b10, 2'd1, 13'd5); idle(5, 2'd1, 13'd5, 2'b01);   // same row
      cyc(1'b1, 2'b10, 2'd1, 13'd5); idle(5, 2'd2, 13'd5, 2'b01);   // other bank
      cyc(1'b1, 2'b10, 2'd1, 13'd5); idle(5, 2'd1, 13'd6, 2'b01);   // other row
      cyc(1'b1, 2'b10, 2'd0, 13'd9); idle(5, 2'd0, 13'd9, 2'b11);   // precharge
      // R7: rewrite mid-countdown restarts gaps, new target row
      cyc(1'b1, 2'b10, 2'd1, 13'd5); cyc(1'b1, 2'b01, 2'd3, 13'd1);
      cyc(1'b1, 2'b10, 2'd3, 13'd1); idle(5, 2'd1, 13'd5, 2'b01);
    end
    // R7: gaps captured at write time, register change afterwards has no effect
    reg_wr(OFS, 32'h0000_4425);
    cyc(1'b1, 2'b10, 2'd2, 13'd2);
    reg_wr(OFS, 32'h4000_4425);
    idle(5, 2'd0, 13'd0, 2'b11);
    // R8: flag survives a clean rewrite, cleared only by reset
    reg_wr(OFS, 32'h3000_4425);
    reg_wr(OFS, 32'h0000_4425);
    idle(2, 2'd0, 13'd0, 2'b00);
    do_reset();
    idle(3, 2'd1, 13'd5, 2'b01);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule